// File: doc/BRIEF.md
# Four-Plane Graphics Write Datapath

This block sits between an 8-bit host data bus and a display memory split into four 8-bit planes that share one address. Every host write produces four plane bytes and a per-plane write enable from the host byte, a set of per-plane read latches and a group of static configuration inputs. The configuration covers a right rotation of the host byte, a per-plane fill pattern, a logic operation against the latches, a bit mask and a plane write mask. Four write modes choose how these are combined.

A host read fetches the addressed location of all four planes at once. It loads the four latches, which later writes then combine with, and returns either the byte of one selected plane or a colour-compare byte. Each bit of the compare byte reports whether the four plane bits at that position equal a 4-bit compare colour, with chosen planes left out of the test. The planes are held in a small internal register array. Host address windowing is left to the surrounding logic.

Top module: `planar_write_path`

## Requirements
- R1: After synchronous reset, host_rdata is 0, every cell of every plane is 0 and all four latches are 0.
- R2: A host read at address A loads all four latches from location A and, one cycle later, shows on host_rdata the byte of the plane selected by cfg_rd_plane (value n selects plane n), provided compare mode is off. host_rdata holds its value when no read occurs.
- R3: In write modes 0 and 3 the host byte is first rotated right by cfg_rot positions (bit i of the result is host bit (i + cfg_rot) mod 8). Mode 2 uses the host bits unrotated.
- R4: cfg_func combines the mode's source byte with the plane's latch: 00 passes the source unchanged, 01 ANDs it, 10 ORs it and 11 XORs it.
- R5: In mode 0 (cfg_wmode = 00), a plane whose cfg_fill_en bit is 1 takes its cfg_fill_val bit copied to all 8 bits as source. A plane whose enable bit is 0 takes the rotated host byte.
- R6: In mode 1 (cfg_wmode = 01), every written plane receives its latch unchanged, whatever cfg_func, cfg_bit_mask and the host byte are.
- R7: In mode 2 (cfg_wmode = 10), plane n takes host bit n copied to all 8 bits as source.
- R8: In mode 3 (cfg_wmode = 11), each plane takes its cfg_fill_val bit copied to all 8 bits as source, whatever cfg_fill_en is. The mask used is the rotated host byte ANDed with cfg_bit_mask.
- R9: In modes 0, 2 and 3, bit positions where the mask is 0 are written with the plane's latch bit.
- R10: A host write changes plane n only when bit n of cfg_plane_we is 1. Other planes keep their contents.
- R11: With cfg_cmp_en = 1, bit i of the read result is 1 when, for every plane n with cfg_cmp_ignore bit n at 0, bit i of plane n equals bit n of cfg_cmp_color. If all four planes are ignored, the result is 8'hFF.
- R12: When host_wr and host_rd are both 1 in the same cycle, the read takes place and the write is dropped.
- R13: The latches change only on a host read. Writes and idle cycles leave them as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW | Location in the planes |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read result |
| cfg_wmode | input | 2 | Write mode 0 to 3 |
| cfg_func | input | 2 | Logic operation against the latches |
| cfg_rot | input | 3 | Right rotation of the host byte |
| cfg_fill_val | input | 4 | Per-plane fill bit |
| cfg_fill_en | input | 4 | Per-plane fill enable for mode 0 |
| cfg_bit_mask | input | 8 | Bit positions that may change |
| cfg_plane_we | input | 4 | Per-plane write enable |
| cfg_rd_plane | input | 2 | Plane returned by a plain read |
| cfg_cmp_en | input | 1 | Return a colour-compare result on reads |
| cfg_cmp_color | input | 4 | Compare colour, one bit per plane |
| cfg_cmp_ignore | input | 4 | Planes left out of the compare |

## Verification
A wrong latch value stays hidden until a later write merges with it. It then shows up only after that location is read back: under the bit mask, in mode 1, or through an AND/OR/XOR. So the bench fills each location, reads it to load the latches, writes, and then reads every plane. A fault in the write logic therefore appears within a few cycles of the write in question. A stray plane enable or a write that is not dropped on a read collision changes a plane the bench expects to be untouched. A compare fault shows at host_rdata one cycle after the read.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int NPLANE = 4;
    localparam int DW     = 8;
    localparam int RW     = $clog2(DW);

    typedef logic [DW-1:0] byte_t;
    typedef logic [NPLANE-1:0][DW-1:0] plane_bus_t;

    typedef enum logic [1:0] {
        WM_DIRECT  = 2'b00,
        WM_LATCH   = 2'b01,
        WM_SPREAD  = 2'b10,
        WM_PATTERN = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        FN_PASS = 2'b00,
        FN_AND  = 2'b01,
        FN_OR   = 2'b10,
        FN_XOR  = 2'b11
    } func_e;

    typedef struct packed {
        wmode_e              mode;
        func_e               func;
        logic [NPLANE-1:0]   fill_val;
        logic [NPLANE-1:0]   fill_en;
        byte_t               bit_mask;
        logic [NPLANE-1:0]   plane_we;
    } wcfg_t;

    function automatic byte_t combine(func_e f, byte_t src, byte_t lat);
        byte_t r;
        case (f)
            FN_AND:  r = src & lat;
            FN_OR:   r = src | lat;
            FN_XOR:  r = src ^ lat;
            default: r = src;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pw_rotator.sv
module pw_rotator
    import pw_pkg::*;
(
    input  byte_t         din,
    input  logic [RW-1:0] amt,
    output byte_t         dout
);
    always_comb begin
        for (int i = 0; i < DW; i++) begin
            dout[i] = din[(i + int'(amt)) % DW];
        end
    end
endmodule

// File: rtl/pw_lane.sv
module pw_lane
    import pw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  wmode_e mode,
    input  func_e  func,
    input  logic   fill_val,
    input  logic   fill_en,
    input  logic   host_bit,
    input  byte_t  rot_data,
    input  byte_t  bit_mask,
    input  byte_t  latch,
    output byte_t  plane_out
);
    byte_t src;
    byte_t merged;
    byte_t eff_mask;

    always_comb begin
        case (mode)
            WM_DIRECT:  src = fill_en ? {DW{fill_val}} : rot_data;
            WM_SPREAD:  src = {DW{host_bit}};
            WM_PATTERN: src = {DW{fill_val}};
            default:    src = latch;
        endcase
    end

    assign merged   = combine(func, src, latch);
    assign eff_mask = (mode == WM_PATTERN) ? (rot_data & bit_mask) : bit_mask;

    always_comb begin
        if (mode == WM_LATCH)
            plane_out = latch;
        else
            plane_out = (merged & eff_mask) | (latch & ~eff_mask);
    end

    // R9: positions cleared in the configured mask never leave the latch value
    assert_mask_keeps_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (mode != WM_LATCH) |-> (((plane_out ^ latch) & ~bit_mask) == '0));

endmodule

// File: rtl/pw_store.sv
module pw_store
    import pw_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [NPLANE-1:0] we,
    input  plane_bus_t        wdata,
    output plane_bus_t        cur,
    output plane_bus_t        latch_q
);
    byte_t mem [NPLANE][DEPTH];
    logic  do_write;

    assign do_write = wr_en && !rd_en;

    always_comb begin
        for (int p = 0; p < NPLANE; p++) begin
            cur[p] = mem[p][addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPLANE; p++) begin
                for (int a = 0; a < DEPTH; a++) begin
                    mem[p][a] <= '0;
                end
            end
        end else if (do_write) begin
            for (int p = 0; p < NPLANE; p++) begin
                if (we[p]) mem[p][addr] <= wdata[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        latch_q <= '0;
        else if (rd_en) latch_q <= cur;
    end

    // R13: latches move only on a read
    assert_latch_hold_R13: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(latch_q));

    for (genvar gp = 0; gp < NPLANE; gp++) begin : g_keep
        // R10 and R12: a plane not enabled, or a write colliding with a read, leaves the cell
        assert_cell_kept_R10: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && !rd_en && we[gp]) |=> (mem[gp][$past(addr)] == $past(mem[gp][addr])));
    end

endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
    import pw_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic [1:0]    cfg_wmode,
    input  logic [1:0]    cfg_func,
    input  logic [2:0]    cfg_rot,
    input  logic [3:0]    cfg_fill_val,
    input  logic [3:0]    cfg_fill_en,
    input  logic [7:0]    cfg_bit_mask,
    input  logic [3:0]    cfg_plane_we,
    input  logic [1:0]    cfg_rd_plane,
    input  logic          cfg_cmp_en,
    input  logic [3:0]    cfg_cmp_color,
    input  logic [3:0]    cfg_cmp_ignore
);
    wcfg_t      wcfg;
    byte_t      rot_data;
    plane_bus_t lane_out;
    plane_bus_t cur;
    plane_bus_t latch_q;
    byte_t      cmp_byte;
    byte_t      rd_next;

    assign wcfg.mode     = wmode_e'(cfg_wmode);
    assign wcfg.func     = func_e'(cfg_func);
    assign wcfg.fill_val = cfg_fill_val;
    assign wcfg.fill_en  = cfg_fill_en;
    assign wcfg.bit_mask = cfg_bit_mask;
    assign wcfg.plane_we = cfg_plane_we;

    pw_rotator u_rot (
        .din  (host_wdata),
        .amt  (cfg_rot),
        .dout (rot_data)
    );

    for (genvar gp = 0; gp < NPLANE; gp++) begin : g_lane
        pw_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .mode      (wcfg.mode),
            .func      (wcfg.func),
            .fill_val  (wcfg.fill_val[gp]),
            .fill_en   (wcfg.fill_en[gp]),
            .host_bit  (host_wdata[gp]),
            .rot_data  (rot_data),
            .bit_mask  (wcfg.bit_mask),
            .latch     (latch_q[gp]),
            .plane_out (lane_out[gp])
        );
    end

    pw_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_wr),
        .rd_en   (host_rd),
        .addr    (host_addr),
        .we      (wcfg.plane_we),
        .wdata   (lane_out),
        .cur     (cur),
        .latch_q (latch_q)
    );

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            cmp_byte[i] = 1'b1;
            for (int p = 0; p < NPLANE; p++) begin
                if (!cfg_cmp_ignore[p] && (cur[p][i] != cfg_cmp_color[p]))
                    cmp_byte[i] = 1'b0;
            end
        end
    end

    assign rd_next = cfg_cmp_en ? cmp_byte : cur[cfg_rd_plane];

    always_ff @(posedge clk) begin
        if (rst)          host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_next;
    end

    // R2: a plain read returns the selected plane of the freshly loaded latches
    assert_read_matches_latch_R2: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !cfg_cmp_en) |=> (host_rdata == latch_q[$past(cfg_rd_plane)]));

    // R11: all planes ignored gives an all-ones compare result
    assert_cmp_all_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (host_rd && cfg_cmp_en && (cfg_cmp_ignore == 4'hF)) |=> (host_rdata == 8'hFF));

endmodule

// File: tb/test_planar_write_path.sv
module test_planar_write_path;

    typedef struct packed {
        logic [31:0] pre;
        logic [1:0]  mode;
        logic [1:0]  func;
        logic [2:0]  rot;
        logic [3:0]  srv;
        logic [3:0]  sre;
        logic [7:0]  mask;
        logic [3:0]  pen;
        logic [7:0]  data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h11223344, 2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 8'hA5},
        '{32'hFFFF0F0F, 2'd0, 2'd1, 3'd3, 4'h0, 4'h0, 8'hFF, 4'hF, 8'hF0},
        '{32'h80408001, 2'd0, 2'd2, 3'd0, 4'h4, 4'h5, 8'h0F, 4'hF, 8'h3C},
        '{32'h0F0F0F0F, 2'd0, 2'd3, 3'd1, 4'h0, 4'h0, 8'hAA, 4'h5, 8'h81},
        '{32'hDEADBEEF, 2'd1, 2'd3, 3'd0, 4'h0, 4'h0, 8'h00, 4'hF, 8'hFF},
        '{32'h00FF00FF, 2'd2, 2'd0, 3'd0, 4'h0, 4'h0, 8'hF0, 4'hF, 8'h0A},
        '{32'h01020408, 2'd2, 2'd2, 3'd0, 4'h0, 4'h0, 8'hFF, 4'hB, 8'h05},
        '{32'h12345678, 2'd3, 2'd0, 3'd4, 4'hA, 4'h0, 8'hF7, 4'hF, 8'h3F},
        '{32'hF0F0F0F0, 2'd3, 2'd1, 3'd7, 4'hF, 4'h0, 8'hFF, 4'hF, 8'h81},
        '{32'h5A5A5A5A, 2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 4'h0, 8'h55}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [1:0] cfg_wmode = '0;
    logic [1:0] cfg_func = '0;
    logic [2:0] cfg_rot = '0;
    logic [3:0] cfg_fill_val = '0;
    logic [3:0] cfg_fill_en = '0;
    logic [7:0] cfg_bit_mask = 8'hFF;
    logic [3:0] cfg_plane_we = '0;
    logic [1:0] cfg_rd_plane = '0;
    logic       cfg_cmp_en = 1'b0;
    logic [3:0] cfg_cmp_color = '0;
    logic [3:0] cfg_cmp_ignore = '0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    planar_write_path #(.DEPTH(16)) i_planar_write_path (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cfg_wmode(cfg_wmode), .cfg_func(cfg_func), .cfg_rot(cfg_rot),
        .cfg_fill_val(cfg_fill_val), .cfg_fill_en(cfg_fill_en),
        .cfg_bit_mask(cfg_bit_mask), .cfg_plane_we(cfg_plane_we),
        .cfg_rd_plane(cfg_rd_plane), .cfg_cmp_en(cfg_cmp_en),
        .cfg_cmp_color(cfg_cmp_color), .cfg_cmp_ignore(cfg_cmp_ignore)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Reference model built from the requirement text
    function automatic logic [31:0] model(input logic [31:0] lat, input vec_t v);
        logic [31:0] res;
        logic [7:0]  rot, src, fn, msk, l, o;
        for (int i = 0; i < 8; i++) rot[i] = v.data[(i + int'(v.rot)) % 8];
        for (int p = 0; p < 4; p++) begin
            l = lat[8*p +: 8];
            case (v.mode)
                2'd0: src = v.sre[p] ? {8{v.srv[p]}} : rot;
                2'd2: src = {8{v.data[p]}};
                default: src = {8{v.srv[p]}};
            endcase
            case (v.func)
                2'd1: fn = src & l;
                2'd2: fn = src | l;
                2'd3: fn = src ^ l;
                default: fn = src;
            endcase
            msk = (v.mode == 2'd3) ? (rot & v.mask) : v.mask;
            o = (v.mode == 2'd1) ? l : ((fn & msk) | (l & ~msk));
            res[8*p +: 8] = v.pen[p] ? o : l;
        end
        return res;
    endfunction

    task automatic set_cfg(input vec_t v);
        cfg_wmode = v.mode; cfg_func = v.func; cfg_rot = v.rot;
        cfg_fill_val = v.srv; cfg_fill_en = v.sre;
        cfg_bit_mask = v.mask; cfg_plane_we = v.pen;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, input logic [1:0] pl, output logic [7:0] r);
        host_addr = a; cfg_rd_plane = pl; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        r = host_rdata;
    endtask

    task automatic preload(input logic [3:0] a, input logic [31:0] pat);
        vec_t v;
        v = '{32'h0, 2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 4'h0, 8'h00};
        for (int p = 0; p < 4; p++) begin
            v.pen = 4'b1 << p;
            set_cfg(v);
            do_write(a, pat[8*p +: 8]);
        end
    endtask

    task automatic read_all(input logic [3:0] a, output logic [31:0] r);
        logic [7:0] b;
        cfg_cmp_en = 1'b0;
        for (int p = 0; p < 4; p++) begin
            do_read(a, 2'(p), b);
            r[8*p +: 8] = b;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] got, lat;
        logic [7:0]  b;
        vec_t        v;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 rdata after reset", {24'h0, host_rdata}, 32'h0);
        read_all(4'd5, got);
        check("R1 planes cleared", got, 32'h0);
        v = '{32'h0, 2'd1, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h00};
        set_cfg(v);
        do_write(4'd6, 8'hFF);
        read_all(4'd6, got);
        check("R1 latches cleared (mode 1 copy)", got, 32'h0);

        // Table walk: fill, load latches, write, read back (R2..R10)
        for (int k = 0; k < NV; k++) begin
            v = VECS[k];
            preload(4'(k + 1), v.pre);
            read_all(4'(k + 1), lat);
            check("R2 preload readback", lat, v.pre);
            set_cfg(v);
            do_write(4'(k + 1), v.data);
            read_all(4'(k + 1), got);
            case (v.mode)
                2'd0: check($sformatf("R5/R4/R9/R10 vector %0d", k), got, model(v.pre, v));
                2'd1: check($sformatf("R6 vector %0d", k), got, model(v.pre, v));
                2'd2: check($sformatf("R7/R9/R10 vector %0d", k), got, model(v.pre, v));
                default: check($sformatf("R8/R3 vector %0d", k), got, model(v.pre, v));
            endcase
        end

        // R3: hand case, bit 0 rotated right by one lands on bit 7
        preload(4'd12, 32'h0);
        do_read(4'd12, 2'd0, b);
        v = '{32'h0, 2'd0, 2'd0, 3'd1, 4'h0, 4'h0, 8'hFF, 4'h1, 8'h01};
        set_cfg(v);
        do_write(4'd12, 8'h01);
        read_all(4'd12, got);
        check("R3 rotate right by one", got, 32'h00000080);

        // R7: hand case, host 0x06 spreads bits to planes 1 and 2
        v = '{32'h0, 2'd2, 2'd0, 3'd5, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h06};
        set_cfg(v);
        do_write(4'd12, 8'h06);
        read_all(4'd12, got);
        check("R7 bit spread unrotated", got, 32'h00FFFF00);

        // R11: colour compare
        preload(4'd3, 32'hFFAACCF0);
        cfg_cmp_en = 1'b1; cfg_cmp_color = 4'b1011; cfg_cmp_ignore = 4'b0000;
        do_read(4'd3, 2'd0, b);
        check("R11 compare all planes", {24'h0, b}, 32'h40);
        cfg_cmp_en = 1'b1; cfg_cmp_ignore = 4'b0100;
        do_read(4'd3, 2'd0, b);
        check("R11 compare plane 2 ignored", {24'h0, b}, 32'hC0);
        cfg_cmp_en = 1'b1; cfg_cmp_ignore = 4'b1111;
        do_read(4'd3, 2'd0, b);
        check("R11 all ignored", {24'h0, b}, 32'hFF);
        cfg_cmp_en = 1'b0; cfg_cmp_ignore = 4'b0000;

        // R2: rdata holds without a read
        repeat (3) @(negedge clk);
        check("R2 rdata held", {24'h0, host_rdata}, 32'hFF);

        // R12: simultaneous read and write drops the write
        preload(4'd7, 32'h01020304);
        v = '{32'h0, 2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 8'hFF};
        set_cfg(v);
        host_addr = 4'd7; host_wdata = 8'hFF; cfg_rd_plane = 2'd1;
        host_wr = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        check("R12 read side of collision", {24'h0, host_rdata}, 32'h03);
        read_all(4'd7, got);
        check("R12 write dropped", got, 32'h01020304);

        // R13: latches survive writes and idle cycles
        read_all(4'd3, got);
        v = '{32'h0, 2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h00};
        set_cfg(v);
        do_write(4'd8, 8'h00);
        repeat (4) @(negedge clk);
        v.mode = 2'd1;
        set_cfg(v);
        do_write(4'd9, 8'h55);
        read_all(4'd9, got);
        check("R13 latches kept across write", got, 32'hFFAACCF0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule